// File: doc/BRIEF.md
# Free-Running Timer with Pulse Timestamp Capture

This block holds a 64-bit counter that advances by one on every cycle in which a tick-enable input is high. A compare register, loaded by software, drives a level interrupt for as long as the counter has reached or passed the programmed value. A second input takes an external reference pulse, for example a once-per-second marker. The block brings that pulse into the clock domain, finds its rising edge, and copies the counter into a capture register at that instant. Software reads the capture register to align the local time base with the outside reference.

Each capture sets a status flag. When the capture interrupt is enabled, the flag drives an interrupt output. If a second capture arrives before software has cleared the flag, an overrun flag is set and the capture register takes the newer value.

All registers are reached through one plain request port. Read data comes back on a response pair one cycle after the request. There is no back-pressure: `req_valid` is accepted in every cycle, and the response is presented for exactly one cycle with no ready signal, so the requester must take it when it appears.

Top module: `tstamp_timer`

## Requirements
- R1: After reset the counter, capture register, status bits and control bit are all zero, the compare register is all ones, and both interrupt outputs are low.
- R2: The counter rises by exactly one at each clock edge where `tick_en` is high, and holds its value at every other edge.
- R3: `cmp_irq` is high exactly while the counter, taken as unsigned, is greater than or equal to the compare register (address 1).
- R4: `sync_pulse` passes through two synchroniser flops. Only a low-to-high change counts as an event. The counter value latched is the one present just before the third clock edge after the input was first sampled high. A pulse held high gives one event, and a falling edge gives none.
- R5: An event copies the counter into the capture register (address 2) and sets status bit 0 (address 3).
- R6: An event that arrives while status bit 0 is already set also sets status bit 1, and the capture register takes the newer counter value.
- R7: Writing to the status register clears each bit that is written as one and leaves each bit written as zero unchanged.
- R8: If an event and a write clearing status bit 0 happen in the same cycle, status bit 0 stays set and that event does not set status bit 1.
- R9: `cap_irq` is high exactly while status bit 0 is set and control bit 0 (address 4) is one.
- R10: A read request gets `rsp_valid` high for one cycle on the following cycle, carrying the register value from the request cycle. Unmapped addresses read as zero. Writes to the counter and capture addresses have no effect. Write requests produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| sync_pulse | input | 1 | Asynchronous external reference pulse |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address (0 counter, 1 compare, 2 capture, 3 status, 4 control) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 64 | Read data |
| cmp_irq | output | 1 | Compare interrupt level |
| cap_irq | output | 1 | Capture interrupt level |

## Verification
Read data is due one edge after the request edge. A capture lands on the third edge after the pulse is first sampled. The interrupt levels follow directly from registered state, so they change at the same edge as the state they depend on. The bench drives inputs and samples outputs on falling edges only. Each read queues its expected value when the request is driven, and the monitor compares that value on the next falling edge, where the response must appear. Capture values are predicted from the bench's own count of tick edges, including one case where ticks keep running through the synchroniser delay.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [2:0] {
    SEL_COUNT = 3'd0,
    SEL_CMP   = 3'd1,
    SEL_CAPT  = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_CTRL  = 3'd4
  } reg_sel_e;

  localparam int STAT_CAP_BIT = 0;
  localparam int STAT_OVR_BIT = 1;
  localparam int CTRL_CIE_BIT = 0;
endpackage

// File: rtl/tt_sync_edge.sv
module tt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic event_o
);
  logic [STAGES-1:0] shreg;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      last_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], pulse_in};
      last_q <= shreg[STAGES-1];
    end
  end

  assign event_o = shreg[STAGES-1] & ~last_q;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tick_en) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/tt_capture.sv
module tt_capture #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr_cap,
  input  logic             clr_ovr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             ovr_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (evt) cap_val <= cnt;
      cap_flag <= evt | (cap_flag & ~clr_cap);
      ovr_flag <= (ovr_flag & ~clr_ovr) | (evt & cap_flag & ~clr_cap);
    end
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [CNT_W-1:0] req_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cap_val,
  input  logic             cap_flag,
  input  logic             ovr_flag,
  output logic [CNT_W-1:0] cmp_val,
  output logic             cap_ie,
  output logic             clr_cap,
  output logic             clr_ovr,
  output logic             rsp_valid,
  output logic [CNT_W-1:0] rsp_data
);
  logic             wr_en;
  logic             rd_en;
  logic [CNT_W-1:0] rd_mux;

  assign wr_en   = req_valid & req_write;
  assign rd_en   = req_valid & ~req_write;
  assign clr_cap = wr_en && (req_addr == SEL_STAT) && req_wdata[STAT_CAP_BIT];
  assign clr_ovr = wr_en && (req_addr == SEL_STAT) && req_wdata[STAT_OVR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '1;
      cap_ie  <= 1'b0;
    end else if (wr_en) begin
      if (req_addr == SEL_CMP)  cmp_val <= req_wdata;
      if (req_addr == SEL_CTRL) cap_ie  <= req_wdata[CTRL_CIE_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      SEL_COUNT: rd_mux = cnt;
      SEL_CMP:   rd_mux = cmp_val;
      SEL_CAPT:  rd_mux = cap_val;
      SEL_STAT: begin
        rd_mux[STAT_CAP_BIT] = cap_flag;
        rd_mux[STAT_OVR_BIT] = ovr_flag;
      end
      SEL_CTRL:  rd_mux[CTRL_CIE_BIT] = cap_ie;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer #(
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sync_pulse,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [CNT_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [CNT_W-1:0] rsp_data,
  output logic             cmp_irq,
  output logic             cap_irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] cap_val;
  logic             cap_evt;
  logic             cap_flag;
  logic             ovr_flag;
  logic             cap_ie;
  logic             clr_cap;
  logic             clr_ovr;

  tt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pulse_in(sync_pulse), .event_o(cap_evt)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt)
  );

  tt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt(cap_evt), .cnt(cnt),
    .clr_cap(clr_cap), .clr_ovr(clr_ovr),
    .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  tt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .cnt(cnt), .cap_val(cap_val),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag),
    .cmp_val(cmp_val), .cap_ie(cap_ie), .clr_cap(clr_cap), .clr_ovr(clr_ovr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign cmp_irq = (cnt >= cmp_val);
  assign cap_irq = cap_flag & cap_ie;
endmodule

// File: rtl/tt_chk.sv
module tt_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [CNT_W-1:0] cnt,
  input logic             evt,
  input logic             cap_flag,
  input logic             ovr_flag,
  input logic [CNT_W-1:0] cap_val,
  input logic             clr_cap,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid
);
  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == $past(cnt) + CNT_W'(1));
  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  // R5
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap_flag && cap_val == $past(cnt));
  // R6
  cap_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cap_flag && !clr_cap) |=> ovr_flag);
  // R8
  cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr_cap) |=> cap_flag);
  // R10
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R10
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind tstamp_timer tt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt), .evt(cap_evt),
  .cap_flag(cap_flag), .ovr_flag(ovr_flag), .cap_val(cap_val),
  .clr_cap(clr_cap), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid)
);

// File: tb/test_tstamp_timer.sv
module test_tstamp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic         sync_pulse = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [2:0]   req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic         rsp_valid;
  logic [W-1:0] rsp_data;
  logic         cmp_irq;
  logic         cap_irq;

  int vectors = 0;
  int misses = 0;
  logic [W-1:0] mcnt = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_timer i_tstamp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sync_pulse(sync_pulse),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cmp_irq(cmp_irq), .cap_irq(cap_irq)
  );

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rsp_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        misses++;
        $display("FAIL R10 unexpected response: got %h expected none", rsp_data);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          misses++;
          $display("FAIL %s: got %h expected %h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic chk_bit(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    mcnt += W'(n);
  endtask

  task automatic pulse(input int hold);
    @(negedge clk);
    sync_pulse = 1'b1;
    repeat (hold) @(negedge clk);
    sync_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_bit(cmp_irq, 1'b0, "R1 cmp_irq");
    chk_bit(cap_irq, 1'b0, "R1 cap_irq");
    rd(3'd0, '0, "R1 counter");
    rd(3'd1, '1, "R1 compare");
    rd(3'd2, '0, "R1 capture");
    rd(3'd3, '0, "R1 status");
    rd(3'd4, '0, "R1 control");
    rd(3'd7, '0, "R10 unmapped");

    // R2 counting and holding
    ticks(10);
    rd(3'd0, mcnt, "R2 count after ticks");
    repeat (5) @(negedge clk);
    rd(3'd0, mcnt, "R2 count held");

    // R3 compare
    wr(3'd1, W'(12));
    chk_bit(cmp_irq, 1'b0, "R3 below compare");
    ticks(2);
    chk_bit(cmp_irq, 1'b1, "R3 equal compare");
    ticks(1);
    chk_bit(cmp_irq, 1'b1, "R3 above compare");
    wr(3'd1, W'(100));
    chk_bit(cmp_irq, 1'b0, "R3 compare raised");
    wr(3'd0, '0);
    wr(3'd2, W'(5));
    rd(3'd0, mcnt, "R10 counter write ignored");
    rd(3'd2, '0, "R10 capture write ignored");

    // R5 first capture, R9 enable
    pulse(1);
    rd(3'd2, mcnt, "R5 capture value");
    rd(3'd3, W'(1), "R5 status set");
    chk_bit(cap_irq, 1'b0, "R9 disabled");
    wr(3'd4, W'(1));
    chk_bit(cap_irq, 1'b1, "R9 enabled");

    // R7 clear, R4 held pulse gives one event
    wr(3'd3, W'(1));
    chk_bit(cap_irq, 1'b0, "R7 clear drops irq");
    ticks(4);
    pulse(10);
    rd(3'd3, W'(1), "R4 held pulse single event");
    rd(3'd2, mcnt, "R4 held pulse value");
    repeat (6) @(negedge clk);
    rd(3'd3, W'(1), "R4 falling edge no event");

    // R6 overrun
    ticks(3);
    pulse(1);
    rd(3'd3, W'(3), "R6 overrun set");
    rd(3'd2, mcnt, "R6 capture overwritten");

    // R7 write-one-to-clear
    wr(3'd3, W'(0));
    rd(3'd3, W'(3), "R7 zero write no effect");
    wr(3'd3, W'(2));
    rd(3'd3, W'(1), "R7 clear overrun only");

    // R8 capture in the same cycle as a clear
    ticks(1);
    @(negedge clk);
    sync_pulse = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd3; req_wdata = W'(1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; sync_pulse = 1'b0;
    rd(3'd3, W'(1), "R8 capture wins over clear");
    rd(3'd2, mcnt, "R8 capture value");

    // R4 latency with ticks running: value before third edge
    wr(3'd3, W'(3));
    @(negedge clk);
    tick_en = 1'b1; sync_pulse = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0; sync_pulse = 1'b0;
    rd(3'd2, mcnt + W'(2), "R4 capture latency");
    mcnt += W'(3);
    rd(3'd0, mcnt, "R2 count after run");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      misses++;
      $display("FAIL R10 missing responses: got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule